// File: doc/BRIEF.md
# Waveform-Mode Timer Channel with Edge-Triggered Restart

This block is one 16-bit timer channel working in waveform mode. A counting clock, shown as a one-cycle `tick` strobe, steps the counter whenever the channel is running. Four counting patterns are available: plain up counting, up/down counting, and each of these with an automatic action when the count matches a programmable compare value RC. The channel can stop its own counting clock when the count reaches RC. It can also be restarted from zero by a selectable external event (the B line or one of three auxiliary inputs) on a selectable edge, or by a software trigger command.

Software writes a 9-bit configuration word and the RC value. It issues one-cycle start, stop and software-trigger commands. It reads three sticky flags (RC compare, overflow, event), which are cleared by a read strobe. The B line drive enable goes low whenever the B line serves as the event input.

The controller has four states. `ST_IDLE` is waveform disabled, with the counter held. `ST_HALT` is waveform enabled with the counting clock stopped. `ST_UP` and `ST_DOWN` are running in either direction. The transitions are as follows:
- IDLE→HALT when the waveform bit is set.
- Any state→IDLE when the waveform bit is cleared.
- HALT→UP on a start command or a trigger.
- UP/DOWN→HALT on a stop command or on an RC match with the stop bit set.
- UP→DOWN at the turning point in the up/down modes, and DOWN→UP at zero.
- Any running or halted state→UP with count 0 on a trigger.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset, `count` is 0, all three flags are 0, `b_oe` is 0, waveform mode is off and ticks do not change the count.
- R2: With configuration bit 0 (waveform enable) at 0, the counter is held: ticks, the start command and the software trigger leave `count` unchanged, and `b_oe` is 0.
- R3: Mode field bits [2:1] = 0: while running, each tick adds 1. From 0xFFFF the count wraps to 0 and sets `flag_ovf`.
- R4: Mode 1: while running, the count climbs to 0xFFFF. The next tick sets `flag_ovf` and turns the count downward (0xFFFE). At 0 the next tick turns it up again (1).
- R5: Mode 2: the tick that brings the count to RC sets `flag_rc`. The next tick reloads the count to 0.
- R6: Mode 3: on the tick while the count equals RC, the direction turns down (RC-1). On the tick while the count is 0 in the down direction, the direction turns up (1).
- R7: With bit [3] (stop on RC) at 1, the tick that brings the count to RC stops the counting clock. Further ticks leave the count unchanged until a start command or trigger.
- R8: `cmd_start` starts the counting clock and `cmd_stop` stops it. When both are high in one cycle, the clock ends up stopped.
- R9: Bits [7:6] select the event source: 0 is `b_in`, and 1, 2 and 3 are `aux_in[0]`, `aux_in[1]` and `aux_in[2]`. Bits [5:4] select the edge: 0 none, 1 rising, 2 falling, 3 both. An input is synchronized by two flops, so a qualified edge driven before a clock edge gives `count` = 0 after the third clock edge. Each qualified edge gives exactly one trigger.
- R10: With bit [8] (event trigger enable) at 1, a qualified event sets the count to 0 and starts the counting clock. At 0, the event leaves the count and the clock untouched, but it still sets `flag_evt`.
- R11: `cmd_swtrig` in waveform mode acts as an event: the count becomes 0 on the next clock and the counting clock starts.
- R12: `b_oe` is 1 exactly when waveform mode is on and the event source is not 0.
- R13: The flags are sticky. `stat_rd` clears all three on the next clock, except that a flag set in the same cycle stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counting clock strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration word (fields in R2 to R10) |
| rc_we | input | 1 | RC write strobe |
| rc_wdata | input | 16 | RC compare value |
| cmd_start | input | 1 | Start counting clock |
| cmd_stop | input | 1 | Stop counting clock |
| cmd_swtrig | input | 1 | Software trigger |
| stat_rd | input | 1 | Flag read strobe, clears flags |
| aux_in | input | 3 | Auxiliary event inputs |
| b_in | input | 1 | B line input level |
| count | output | 16 | Counter value |
| b_oe | output | 1 | B line drive enable |
| flag_rc | output | 1 | Sticky RC compare flag |
| flag_ovf | output | 1 | Sticky overflow flag |
| flag_evt | output | 1 | Sticky external event flag |

## Verification
Directed sequences cover each counting mode at its turning points. They include long runs to 0xFFFF, which separate wrap-to-zero from reversal and show when the overflow flag rises. Small RC values separate reload from reversal and from self-stop. Event stimulus switches a selected input with each edge setting. It shows that the matching edge restarts the count exactly three clocks later, that the opposite edge, the "none" setting and a disabled trigger leave the count alone, and that a both-edges setting gives one restart per edge and not more. Seeded random tick patterns in all four modes with random RC are compared cycle by cycle against a bench model, which catches off-by-one errors at the compare value.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        MD_UP      = 2'd0,
        MD_UPDN    = 2'd1,
        MD_UP_RC   = 2'd2,
        MD_UPDN_RC = 2'd3
    } wtc_mode_e;

    typedef enum logic [1:0] {
        EG_NONE = 2'd0,
        EG_RISE = 2'd1,
        EG_FALL = 2'd2,
        EG_BOTH = 2'd3
    } wtc_edge_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HALT = 2'd1,
        ST_UP   = 2'd2,
        ST_DOWN = 2'd3
    } wtc_state_e;

    typedef struct packed {
        logic       trig_en;
        logic [1:0] src;
        wtc_edge_e  edge_sel;
        logic       stop_on_rc;
        wtc_mode_e  mode;
        logic       wave_en;
    } wtc_cfg_t;

    localparam int CFG_W = $bits(wtc_cfg_t);

endpackage

// File: rtl/wtc_evt_sync.sv
module wtc_evt_sync
    import wtc_pkg::*;
#(
    parameter int N_SRC       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic [SEL_W-1:0] sel,
    input  wtc_edge_e        edge_sel,
    output logic             evt_pulse
);

    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] fall;

    // one synchronizer plus a history flop for each source
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [SYNC_STAGES:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '0;
            end else begin
                pipe <= {pipe[SYNC_STAGES-1:0], src_in[g]};
            end
        end
        assign rise[g] = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
        assign fall[g] = ~pipe[SYNC_STAGES-1] & pipe[SYNC_STAGES];
    end

    always_comb begin
        unique case (edge_sel)
            EG_NONE: evt_pulse = 1'b0;
            EG_RISE: evt_pulse = rise[sel];
            EG_FALL: evt_pulse = fall[sel];
            EG_BOTH: evt_pulse = rise[sel] | fall[sel];
        endcase
    end

    // R9
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse && edge_sel != EG_BOTH)
        |=> (!evt_pulse || !$stable(sel) || !$stable(edge_sel)));

endmodule

// File: rtl/wtc_count_core.sv
module wtc_count_core
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wave_en,
    input  wtc_mode_e        mode,
    input  logic             stop_on_rc,
    input  logic [CNT_W-1:0] rc,
    input  logic             tick,
    input  logic             trig,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    output logic [CNT_W-1:0] cnt,
    output logic             rc_hit,
    output logic             ovf_hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    wtc_state_e       st_q, st_n, step_dir;
    logic [CNT_W-1:0] cnt_q, cnt_n, step_val;
    logic             updown, autotrig, running, step_go, ovf_raw;

    assign updown   = (mode == MD_UPDN) || (mode == MD_UPDN_RC);
    assign autotrig = (mode == MD_UP_RC) || (mode == MD_UPDN_RC);
    assign running  = (st_q == ST_UP) || (st_q == ST_DOWN);
    assign step_go  = wave_en && running && tick && !trig;

    // value and direction after one counting step
    always_comb begin
        step_val = cnt_q;
        step_dir = st_q;
        ovf_raw  = 1'b0;
        if (st_q == ST_DOWN && updown) begin
            if (cnt_q == '0) begin
                step_val = CNT_ONE;
                step_dir = ST_UP;
            end else begin
                step_val = cnt_q - CNT_ONE;
            end
        end else begin
            step_dir = ST_UP;
            if (autotrig && cnt_q == rc) begin
                if (updown) begin
                    step_dir = ST_DOWN;
                    step_val = (cnt_q == '0) ? '0 : cnt_q - CNT_ONE;
                end else begin
                    step_val = '0;
                end
            end else if (cnt_q == CNT_MAX) begin
                ovf_raw = 1'b1;
                if (updown) begin
                    step_val = CNT_MAX - CNT_ONE;
                    step_dir = ST_DOWN;
                end else begin
                    step_val = '0;
                end
            end else begin
                step_val = cnt_q + CNT_ONE;
            end
        end
    end

    assign rc_hit  = step_go && (step_val == rc);
    assign ovf_hit = step_go && ovf_raw;

    // next state and next count
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (wave_en) st_n = ST_HALT;
            end
            ST_HALT: begin
                if (trig) begin
                    cnt_n = '0;
                    st_n  = cmd_stop ? ST_HALT : ST_UP;
                end else if (cmd_start && !cmd_stop) begin
                    st_n = ST_UP;
                end
            end
            ST_UP, ST_DOWN: begin
                if (trig) begin
                    cnt_n = '0;
                    st_n  = cmd_stop ? ST_HALT : ST_UP;
                end else begin
                    if (tick) begin
                        cnt_n = step_val;
                        st_n  = step_dir;
                    end
                    if (cmd_stop || (rc_hit && stop_on_rc)) st_n = ST_HALT;
                end
            end
        endcase
        if (!wave_en) begin
            st_n  = ST_IDLE;
            cnt_n = cnt_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_n;
    end

    assign cnt = cnt_q;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> (cnt_q == $past(cnt_q)));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !trig) |=> $stable(cnt_q));

    // R10
    trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && wave_en && st_q != ST_IDLE) |=> (cnt_q == '0));

    // R3
    up_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_go && st_q == ST_UP && mode == MD_UP && cnt_q != CNT_MAX)
        |=> (cnt_q == $past(cnt_q) + CNT_ONE));

    // R7
    rc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_hit && stop_on_rc) |=> (st_q == ST_HALT));

endmodule

// File: rtl/wtc_flags.sv
module wtc_flags #(
    parameter int N_FLAGS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set,
    input  logic               clr,
    output logic [N_FLAGS-1:0] flags
);

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[g] <= 1'b0;
            else if (set[g]) flags[g] <= 1'b1;
            else if (clr)    flags[g] <= 1'b0;
        end

        // R13
        flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set[g]) |=> !flags[g]);

        // R13
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flags[g]);
    end

endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_AUX = 3,
    localparam int N_SRC = N_AUX + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rc_we,
    input  logic [CNT_W-1:0] rc_wdata,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cmd_swtrig,
    input  logic             stat_rd,
    input  logic [N_AUX-1:0] aux_in,
    input  logic             b_in,
    output logic [CNT_W-1:0] count,
    output logic             b_oe,
    output logic             flag_rc,
    output logic             flag_ovf,
    output logic             flag_evt
);

    wtc_cfg_t         cfg_q, cfg_new;
    logic [CNT_W-1:0] rc_q;
    logic             evt_pulse, trig, rc_hit, ovf_hit;
    logic [2:0]       flag_set, flag_q;

    assign cfg_new = wtc_cfg_t'(cfg_wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            rc_q  <= '0;
        end else begin
            if (cfg_we) cfg_q <= cfg_new;
            if (rc_we)  rc_q  <= rc_wdata;
        end
    end

    wtc_evt_sync #(
        .N_SRC       (N_SRC),
        .SYNC_STAGES (2)
    ) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    ({aux_in, b_in}),
        .sel       (cfg_q.src),
        .edge_sel  (cfg_q.edge_sel),
        .evt_pulse (evt_pulse)
    );

    assign trig = cfg_q.wave_en && ((evt_pulse && cfg_q.trig_en) || cmd_swtrig);

    wtc_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wave_en    (cfg_q.wave_en),
        .mode       (cfg_q.mode),
        .stop_on_rc (cfg_q.stop_on_rc),
        .rc         (rc_q),
        .tick       (tick),
        .trig       (trig),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cnt        (count),
        .rc_hit     (rc_hit),
        .ovf_hit    (ovf_hit)
    );

    assign flag_set = {evt_pulse && cfg_q.wave_en, ovf_hit, rc_hit};

    wtc_flags #(
        .N_FLAGS (3)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (stat_rd),
        .flags (flag_q)
    );

    assign flag_rc  = flag_q[0];
    assign flag_ovf = flag_q[1];
    assign flag_evt = flag_q[2];

    // B line is an input whenever it is the event source
    assign b_oe = cfg_q.wave_en && (cfg_q.src != 2'd0);

    // R12
    b_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_new.src == 2'd0) |=> !b_oe);

    // R12
    b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_new.wave_en) |=> !b_oe);

endmodule

// File: tb/test_wave_timer_chan.sv
module test_wave_timer_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [8:0]  cfg_wdata = '0;
    logic        rc_we = 1'b0;
    logic [15:0] rc_wdata = '0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        cmd_swtrig = 1'b0;
    logic        stat_rd = 1'b0;
    logic [2:0]  aux_in = '0;
    logic        b_in = 1'b0;
    logic [15:0] count;
    logic        b_oe, flag_rc, flag_ovf, flag_evt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wave_timer_chan i_wave_timer_chan (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rc_we(rc_we), .rc_wdata(rc_wdata),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_swtrig(cmd_swtrig),
        .stat_rd(stat_rd), .aux_in(aux_in), .b_in(b_in),
        .count(count), .b_oe(b_oe),
        .flag_rc(flag_rc), .flag_ovf(flag_ovf), .flag_evt(flag_evt)
    );

    function automatic logic [8:0] mk_cfg(bit trg, bit [1:0] src, bit [1:0] edg,
                                          bit stop, bit [1:0] mode, bit wave);
        return {trg, src, edg, stop, mode, wave};
    endfunction

    // expected step: returns {down, count}
    function automatic logic [16:0] model_step(bit [1:0] mode, logic [15:0] rc,
                                               logic [15:0] c, bit down);
        bit ud = (mode == 2'd1) || (mode == 2'd3);
        bit at = mode[1];
        if (down && ud) begin
            if (c == 16'd0) return {1'b0, 16'd1};
            return {1'b1, c - 16'd1};
        end
        if (at && c == rc) begin
            if (ud) return {1'b1, (c == 16'd0) ? 16'd0 : c - 16'd1};
            return {1'b0, 16'd0};
        end
        if (c == 16'hFFFF) return ud ? {1'b1, 16'hFFFE} : {1'b0, 16'd0};
        return {1'b0, c + 16'd1};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wr_cfg(logic [8:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_rc(logic [15:0] v);
        rc_we = 1'b1; rc_wdata = v;
        @(negedge clk);
        rc_we = 1'b0;
    endtask

    task automatic do_start();
        cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic do_stop();
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
    endtask

    task automatic do_trig();
        cmd_swtrig = 1'b1; @(negedge clk); cmd_swtrig = 1'b0;
    endtask

    task automatic clr_flags();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [16:0] nx;
        logic [15:0] mc;
        bit          md;
        void'($urandom(32'h5EED_0042));
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 flags", {flag_rc, flag_ovf, flag_evt}, 0);
        chk("R1 b_oe", b_oe, 0);
        ticks(3);
        chk("R1 ticks before enable", count, 0);

        // R3 basic up counting, R12 output enable
        wr_cfg(mk_cfg(0, 2'd1, 2'd0, 0, 2'd0, 1));
        chk("R12 b_oe aux source", b_oe, 1);
        do_start();
        ticks(5);
        chk("R3 count after 5 ticks", count, 5);

        // R8 stop, then stop+start together
        do_stop();
        ticks(4);
        chk("R8 stopped", count, 5);
        cmd_start = 1'b1; cmd_stop = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0;
        ticks(3);
        chk("R8 stop wins", count, 5);
        do_start();
        ticks(1);
        chk("R8 restart", count, 6);

        // R2 capture mode holds
        wr_cfg(mk_cfg(0, 2'd1, 2'd0, 0, 2'd0, 0));
        chk("R2 b_oe off", b_oe, 0);
        ticks(3);
        do_start();
        do_trig();
        ticks(3);
        chk("R2 held in capture mode", count, 6);

        // R5 reload on RC
        wr_rc(16'd5);
        wr_cfg(mk_cfg(0, 2'd1, 2'd0, 0, 2'd2, 1));
        do_trig();
        chk("R11 software trigger zero", count, 0);
        clr_flags();
        ticks(5);
        chk("R5 count at RC", count, 5);
        chk("R5 rc flag", flag_rc, 1);
        ticks(1);
        chk("R5 reload", count, 0);

        // R13 read clear and set priority
        clr_flags();
        chk("R13 cleared", {flag_rc, flag_ovf, flag_evt}, 0);
        ticks(4);
        tick = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        tick = 1'b0; stat_rd = 1'b0;
        chk("R13 count", count, 5);
        chk("R13 set wins", flag_rc, 1);
        clr_flags();
        chk("R13 cleared again", flag_rc, 0);

        // R6 up/down with RC
        wr_rc(16'd4);
        wr_cfg(mk_cfg(0, 2'd1, 2'd0, 0, 2'd3, 1));
        do_trig();
        ticks(6);
        chk("R6 turn down at RC", count, 2);
        ticks(3);
        chk("R6 turn up at zero", count, 1);

        // R7 stop on RC
        wr_rc(16'd3);
        wr_cfg(mk_cfg(0, 2'd1, 2'd0, 1, 2'd0, 1));
        do_trig();
        clr_flags();
        ticks(10);
        chk("R7 stopped at RC", count, 3);
        chk("R7 rc flag", flag_rc, 1);
        do_start();
        ticks(1);
        chk("R7 resumes", count, 4);

        // R9 rising edge on aux_in[1]
        wr_cfg(mk_cfg(1, 2'd2, 2'd1, 0, 2'd0, 1));
        do_trig();
        ticks(7);
        clr_flags();
        aux_in[1] = 1'b1;
        cyc(2);
        chk("R9 not before sync", count, 7);
        cyc(1);
        chk("R9 rise restarts", count, 0);
        chk("R9 event flag", flag_evt, 1);
        ticks(3);
        chk("R10 clock running after event", count, 3);
        aux_in[1] = 1'b0;
        cyc(4);
        chk("R9 falling ignored under rise", count, 3);
        wr_cfg(mk_cfg(1, 2'd2, 2'd2, 0, 2'd0, 1));
        aux_in[1] = 1'b1;
        cyc(4);
        chk("R9 rising ignored under fall", count, 3);
        aux_in[1] = 1'b0;
        cyc(3);
        chk("R9 fall restarts", count, 0);

        // R9 both edges on B line
        wr_cfg(mk_cfg(1, 2'd0, 2'd3, 0, 2'd0, 1));
        chk("R12 b_oe off for B source", b_oe, 0);
        ticks(4);
        chk("R9 counting", count, 4);
        b_in = 1'b1;
        cyc(3);
        chk("R9 both rise", count, 0);
        ticks(2);
        cyc(3);
        chk("R9 one trigger per edge", count, 2);
        b_in = 1'b0;
        cyc(3);
        chk("R9 both fall", count, 0);

        // R9 edge none
        wr_cfg(mk_cfg(1, 2'd0, 2'd0, 0, 2'd0, 1));
        ticks(2);
        clr_flags();
        b_in = 1'b1;
        cyc(4);
        chk("R9 none no trigger", count, 2);
        chk("R9 none no flag", flag_evt, 0);

        // R10 trigger disabled, then enabled from halt
        wr_cfg(mk_cfg(0, 2'd3, 2'd1, 0, 2'd0, 1));
        do_stop();
        clr_flags();
        aux_in[2] = 1'b1;
        cyc(4);
        ticks(3);
        chk("R10 disabled no effect", count, 2);
        chk("R10 flag still set", flag_evt, 1);
        wr_cfg(mk_cfg(1, 2'd3, 2'd1, 0, 2'd0, 1));
        aux_in[2] = 1'b0;
        cyc(3);
        aux_in[2] = 1'b1;
        cyc(3);
        chk("R10 event zeroes", count, 0);
        ticks(2);
        chk("R10 event starts clock", count, 2);

        // R11 software trigger from halt
        do_stop();
        do_trig();
        ticks(3);
        chk("R11 trigger starts clock", count, 3);

        // R4 up/down turning at the top
        wr_cfg(mk_cfg(0, 2'd1, 2'd0, 0, 2'd1, 1));
        do_trig();
        ticks(65535);
        chk("R4 reaches top", count, 16'hFFFF);
        clr_flags();
        ticks(1);
        chk("R4 turns down", count, 16'hFFFE);
        chk("R4 overflow flag", flag_ovf, 1);
        ticks(2);
        chk("R4 keeps falling", count, 16'hFFFC);

        // R3 wrap
        wr_cfg(mk_cfg(0, 2'd1, 2'd0, 0, 2'd0, 1));
        do_trig();
        ticks(65535);
        clr_flags();
        chk("R3 at top", count, 16'hFFFF);
        ticks(1);
        chk("R3 wrap", count, 0);
        chk("R3 overflow flag", flag_ovf, 1);

        // random tick patterns against the model (R3 R4 R5 R6)
        for (int run = 0; run < 8; run++) begin
            bit [1:0]    m = 2'($urandom % 4);
            logic [15:0] r = 16'(2 + ($urandom % 40));
            wr_rc(r);
            wr_cfg(mk_cfg(0, 2'd1, 2'd0, 0, m, 1));
            do_trig();
            mc = 16'd0;
            md = 1'b0;
            for (int i = 0; i < 200; i++) begin
                bit t = 1'($urandom % 2);
                tick = t;
                @(negedge clk);
                if (t) begin
                    nx = model_step(m, r, mc, md);
                    md = nx[16];
                    mc = nx[15:0];
                end
                chk($sformatf("R3 R4 R5 R6 random mode %0d", m), count, mc);
            end
            tick = 1'b0;
        end

        summary();
    end

endmodule